// File: doc/BRIEF.md
# SPI Controller Interrupt Status Unit

This block collects the interrupt sources of an SPI controller whose transmit and receive FIFOs hold 32-bit words. It takes the live word counts of both FIFOs and two single-cycle error strobes (receive overflow, transmit underflow). From these it forms a status word in which the FIFO conditions are level bits and the two error events are sticky bits. It drives one active-high interrupt line from the status bits that software has unmasked.

Software reaches the unit through a simple register port: a write strobe with address and data, and a combinational read-data bus. The mask cannot be written directly. One register only sets mask bits and another only clears them, so two agents can change different sources without a read-modify-write race. Two threshold registers tune the FIFO conditions. The receive "not empty" bit means "at least N words waiting". The transmit "not full" bit means "fewer than N words queued". With N = 1 the transmit bit therefore signals an empty FIFO.

Top module: `spi_irq_status`

## Requirements
- R1: After reset the mask reads 0, both thresholds read 1, the sticky bits are clear and `irq` is low.
- R2: The status register (offset 0x04) reads receive overflow at bit 0, transmit not-full at bit 2, transmit full at bit 3, receive not-empty at bit 4, receive full at bit 5 and transmit underflow at bit 6. Bit 1 and bits 31:7 read 0. The full bits are set while the matching count equals `FIFO_DEPTH`, and all level bits follow the counts in the same cycle.
- R3: Transmit not-full is 1 exactly when `tx_count` is below the transmit threshold (offset 0x28). With the threshold at 1 it is set only when the FIFO is empty, and with the threshold at 0 it is never set.
- R4: Receive not-empty is 1 exactly when `rx_count` is at least the receive threshold (offset 0x2C). With the threshold at 0 it is always set.
- R5: A strobe on `rx_ovf_evt` or `tx_udf_evt` sets its sticky bit from the next cycle on. The bit stays set until a 1 is written to its own bit of the status register. Writing 0 to a sticky bit, or writing anything to the level bits, changes nothing.
- R6: When an event strobe and a write-1-to-clear of the same bit fall in the same cycle, the bit remains set.
- R7: Writing to offset 0x08 sets every implemented mask bit that is 1 in the data, and writing to offset 0x0C clears every mask bit that is 1 in the data. Zero data bits leave the mask unchanged. The mask reads at offset 0x10, where writes are ignored. Offsets 0x08 and 0x0C read 0.
- R8: `irq` equals the OR of (status AND mask) as it stood in the previous cycle.
- R9: Writing all ones to the status register and then all ones to offset 0x0C clears both sticky bits and leaves the mask at 0, which drives `irq` low.
- R10: A threshold write keeps only the low `CNT_W` data bits (6 bits by default) and reads back as stored. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_count | input | CNT_W | Words currently held in the transmit FIFO |
| rx_count | input | CNT_W | Words currently held in the receive FIFO |
| rx_ovf_evt | input | 1 | One-cycle strobe: receive FIFO overflowed |
| tx_udf_evt | input | 1 | One-cycle strobe: transmit FIFO underflowed |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request, active high, registered |

## Verification
The embedded properties assume that the FIFO counts never exceed `FIFO_DEPTH` and that at most one register is written per cycle. Because the port carries a single address, the second assumption holds by construction. The stimulus keeps both counts within 0 to 63, and it raises the event strobes for single cycles only, sometimes in the same cycle as a clearing write to test the collision rule. A behavioural model in the bench predicts the read data and the interrupt line every cycle. The bench sweeps thresholds across 0, 1, mid-range and oversize values so that each comparison is exercised at its boundary.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    // status word layout; software decodes these positions
    localparam int STAT_W     = 7;
    localparam int BIT_OVF    = 0;
    localparam int BIT_TXNF   = 2;
    localparam int BIT_TXFULL = 3;
    localparam int BIT_RXNE   = 4;
    localparam int BIT_RXFULL = 5;
    localparam int BIT_UDF    = 6;

    // bits that exist in the mask (bit 1 is unimplemented)
    localparam logic [STAT_W-1:0] IMPL_MASK = 7'b111_1101;

    // register offsets
    localparam int ADR_STAT  = 'h04;
    localparam int ADR_EN    = 'h08;
    localparam int ADR_DIS   = 'h0C;
    localparam int ADR_MASK  = 'h10;
    localparam int ADR_TXTHR = 'h28;
    localparam int ADR_RXTHR = 'h2C;

    typedef struct packed {
        logic tx_nf;
        logic tx_full;
        logic rx_ne;
        logic rx_full;
    } fifo_lvl_t;

    function automatic logic [STAT_W-1:0] pack_status(
        input logic      ovf,
        input logic      udf,
        input fifo_lvl_t lvl
    );
        logic [STAT_W-1:0] s;
        s             = '0;
        s[BIT_OVF]    = ovf;
        s[BIT_TXNF]   = lvl.tx_nf;
        s[BIT_TXFULL] = lvl.tx_full;
        s[BIT_RXNE]   = lvl.rx_ne;
        s[BIT_RXFULL] = lvl.rx_full;
        s[BIT_UDF]    = udf;
        return s;
    endfunction

endpackage

// File: rtl/spi_irq_levels.sv
module spi_irq_levels
    import spi_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 63,
    parameter int CNT_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_thr,
    input  logic [CNT_W-1:0] rx_thr,
    output fifo_lvl_t        lvl
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

    always_comb begin
        lvl         = '0;
        lvl.tx_nf   = (tx_count < tx_thr);
        lvl.tx_full = (tx_count == FULL_CNT);
        lvl.rx_ne   = (rx_count >= rx_thr);
        lvl.rx_full = (rx_count == FULL_CNT);
    end

    // R3
    tx_empty_nf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0) && (tx_thr != '0) |-> lvl.tx_nf);

    // R4
    rx_empty_ne_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) && (rx_thr != '0) |-> !lvl.rx_ne);

endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
    import spi_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_ovf_evt,
    input  logic              tx_udf_evt,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [STAT_W-1:0] status,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [STAT_W-1:0] mask,
    output logic              ovf,
    output logic              udf,
    output logic [CNT_W-1:0]  tx_thr,
    output logic [CNT_W-1:0]  rx_thr
);

    typedef struct packed {
        logic [STAT_W-1:0] mask;
        logic              ovf;
        logic              udf;
        logic [CNT_W-1:0]  tx_thr;
        logic [CNT_W-1:0]  rx_thr;
    } regs_t;

    regs_t s_d, s_q;

    logic              wr_stat, wr_en, wr_dis, wr_txthr, wr_rxthr;
    logic [STAT_W-1:0] wbits;
    logic              wdata_unused;

    assign wdata_unused = ^reg_wdata;
    assign wbits        = reg_wdata[STAT_W-1:0];

    always_comb begin
        wr_stat  = reg_wr && (reg_addr == ADDR_W'(ADR_STAT));
        wr_en    = reg_wr && (reg_addr == ADDR_W'(ADR_EN));
        wr_dis   = reg_wr && (reg_addr == ADDR_W'(ADR_DIS));
        wr_txthr = reg_wr && (reg_addr == ADDR_W'(ADR_TXTHR));
        wr_rxthr = reg_wr && (reg_addr == ADDR_W'(ADR_RXTHR));

        s_d = s_q;
        // sticky flags: clear by write-one, event takes priority
        if (wr_stat && wbits[BIT_OVF]) s_d.ovf = 1'b0;
        if (wr_stat && wbits[BIT_UDF]) s_d.udf = 1'b0;
        if (rx_ovf_evt)                s_d.ovf = 1'b1;
        if (tx_udf_evt)                s_d.udf = 1'b1;
        // set-only and clear-only mask access
        if (wr_en)  s_d.mask = s_q.mask | (wbits & IMPL_MASK);
        if (wr_dis) s_d.mask = s_q.mask & ~wbits;
        if (wr_txthr) s_d.tx_thr = reg_wdata[CNT_W-1:0];
        if (wr_rxthr) s_d.rx_thr = reg_wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mask   <= '0;
            s_q.ovf    <= 1'b0;
            s_q.udf    <= 1'b0;
            s_q.tx_thr <= CNT_W'(1);
            s_q.rx_thr <= CNT_W'(1);
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(ADR_STAT):  reg_rdata = DATA_W'(status);
            ADDR_W'(ADR_MASK):  reg_rdata = DATA_W'(s_q.mask);
            ADDR_W'(ADR_TXTHR): reg_rdata = DATA_W'(s_q.tx_thr);
            ADDR_W'(ADR_RXTHR): reg_rdata = DATA_W'(s_q.rx_thr);
            default:            reg_rdata = '0;
        endcase
    end

    assign mask   = s_q.mask;
    assign ovf    = s_q.ovf;
    assign udf    = s_q.udf;
    assign tx_thr = s_q.tx_thr;
    assign rx_thr = s_q.rx_thr;

    // R5
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ovf && !(wr_stat && wbits[BIT_OVF]) |=> s_q.ovf);

    // R5
    udf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.udf && !(wr_stat && wbits[BIT_UDF]) |=> s_q.udf);

    // R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf_evt |=> s_q.ovf);

    // R6
    udf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_udf_evt |=> s_q.udf);

    // R7
    en_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((s_q.mask & $past(wbits & IMPL_MASK)) == $past(wbits & IMPL_MASK)));

    // R7
    dis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dis |=> ((s_q.mask & $past(wbits)) == '0));

    // R7
    mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && !wr_dis |=> $stable(s_q.mask));

endmodule

// File: rtl/spi_irq_out.sv
module spi_irq_out
    import spi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] status,
    input  logic [STAT_W-1:0] mask,
    output logic              irq
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d = |(status & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> !irq);

    // R8
    no_source_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |=> !irq);

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
#(
    parameter  int FIFO_DEPTH = 63,
    parameter  int ADDR_W     = 8,
    parameter  int DATA_W     = 32,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              rx_ovf_evt,
    input  logic              tx_udf_evt,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    fifo_lvl_t         lvl;
    logic [STAT_W-1:0] status;
    logic [STAT_W-1:0] mask;
    logic              ovf, udf;
    logic [CNT_W-1:0]  tx_thr, rx_thr;

    spi_irq_levels #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .CNT_W      (CNT_W)
    ) u_levels (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_count (tx_count),
        .rx_count (rx_count),
        .tx_thr   (tx_thr),
        .rx_thr   (rx_thr),
        .lvl      (lvl)
    );

    assign status = pack_status(ovf, udf, lvl);

    spi_irq_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_ovf_evt (rx_ovf_evt),
        .tx_udf_evt (tx_udf_evt),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .status     (status),
        .reg_rdata  (reg_rdata),
        .mask       (mask),
        .ovf        (ovf),
        .udf        (udf),
        .tx_thr     (tx_thr),
        .rx_thr     (rx_thr)
    );

    spi_irq_out u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status),
        .mask   (mask),
        .irq    (irq)
    );

    // R2
    full_excludes_nf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == CNT_W'(FIFO_DEPTH)) && (tx_thr <= CNT_W'(FIFO_DEPTH)) |-> !status[BIT_TXNF]);

endmodule

// File: tb/test_spi_irq_status.sv
`timescale 1ns/1ps
module test_spi_irq_status;

    localparam int DEPTH = 63;
    localparam int CW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] tx_count = '0;
    logic [CW-1:0] rx_count = '0;
    logic          rx_ovf_evt = 1'b0;
    logic          tx_udf_evt = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // behavioural reference state
    int m_mask  = 0;
    bit m_ovf   = 0;
    bit m_udf   = 0;
    int m_txthr = 1;
    int m_rxthr = 1;
    bit m_irq   = 0;

    always #2 clk = ~clk;

    spi_irq_status i_spi_irq_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_count   (tx_count),
        .rx_count   (rx_count),
        .rx_ovf_evt (rx_ovf_evt),
        .tx_udf_evt (tx_udf_evt),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq)
    );

    function automatic int exp_status(int txc, int rxc);
        int r = 0;
        if (m_ovf)          r |= 'h01;
        if (txc < m_txthr)  r |= 'h04;
        if (txc == DEPTH)   r |= 'h08;
        if (rxc >= m_rxthr) r |= 'h10;
        if (rxc == DEPTH)   r |= 'h20;
        if (m_udf)          r |= 'h40;
        return r;
    endfunction

    function automatic int exp_read(int a, int txc, int rxc);
        case (a)
            'h04:    return exp_status(txc, rxc);
            'h10:    return m_mask;
            'h28:    return m_txthr;
            'h2C:    return m_rxthr;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // one cycle: drive, compare, advance model at the edge
    task automatic step(input int a, input bit w, input int d,
                        input int txc, input int rxc,
                        input bit ev_ovf, input bit ev_udf, input string tag);
        int st;
        reg_addr   = 8'(a);
        reg_wr     = w;
        reg_wdata  = d;
        tx_count   = CW'(txc);
        rx_count   = CW'(rxc);
        rx_ovf_evt = ev_ovf;
        tx_udf_evt = ev_udf;
        #1;
        check(tag, int'(reg_rdata), exp_read(a, txc, rxc));
        check("R8", int'(irq), int'(m_irq));
        @(posedge clk);
        st    = exp_status(txc, rxc);
        m_irq = ((st & m_mask) != 0);
        if (w) begin
            case (a)
                'h04: begin
                    if (d[0]) m_ovf = 0;
                    if (d[6]) m_udf = 0;
                end
                'h08: m_mask = m_mask | (d & 'h7D);
                'h0C: m_mask = m_mask & ~d & 'h7F;
                'h28: m_txthr = d & 'h3F;
                'h2C: m_rxthr = d & 'h3F;
                default: ;
            endcase
        end
        if (ev_ovf) m_ovf = 1;
        if (ev_udf) m_udf = 1;
        @(negedge clk);
    endtask

    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        step('h10, 0, 0, 0, 0, 0, 0, "R1");
        step('h28, 0, 0, 0, 0, 0, 0, "R1");
        step('h2C, 0, 0, 0, 0, 0, 0, "R1");
        step('h04, 0, 0, 0, 0, 0, 0, "R1");

        // R2 level bits follow counts live
        step('h04, 0, 0, 1, 1, 0, 0, "R2");
        step('h04, 0, 0, 63, 0, 0, 0, "R2");
        step('h04, 0, 0, 5, 63, 0, 0, "R2");
        step('h04, 0, 0, 62, 62, 0, 0, "R2");

        // R3 transmit threshold
        step('h28, 1, 8, 0, 0, 0, 0, "R3");
        step('h04, 0, 0, 7, 0, 0, 0, "R3");
        step('h04, 0, 0, 8, 0, 0, 0, "R3");
        step('h28, 1, 0, 0, 0, 0, 0, "R3");
        step('h04, 0, 0, 0, 0, 0, 0, "R3");
        step('h28, 1, 1, 0, 0, 0, 0, "R3");
        step('h04, 0, 0, 1, 0, 0, 0, "R3");

        // R4 receive threshold
        step('h2C, 1, 4, 0, 0, 0, 0, "R4");
        step('h04, 0, 0, 1, 3, 0, 0, "R4");
        step('h04, 0, 0, 1, 4, 0, 0, "R4");
        step('h2C, 1, 0, 1, 0, 0, 0, "R4");
        step('h04, 0, 0, 1, 0, 0, 0, "R4");
        step('h2C, 1, 1, 1, 0, 0, 0, "R4");

        // R5 sticky bits
        step('h04, 0, 0, 1, 0, 1, 0, "R5");
        step('h04, 0, 0, 1, 0, 0, 1, "R5");
        step('h04, 1, 0, 1, 0, 0, 0, "R5");
        step('h04, 1, 'h3C, 1, 0, 0, 0, "R5");
        step('h04, 1, 'h01, 1, 0, 0, 0, "R5");
        step('h04, 1, 'h40, 1, 0, 0, 0, "R5");
        step('h04, 0, 0, 1, 0, 0, 0, "R5");

        // R6 event beats clear
        step('h04, 1, 'h41, 1, 0, 1, 1, "R6");
        step('h04, 0, 0, 1, 0, 0, 0, "R6");

        // R7 mask set/clear
        step('h08, 1, 'h11, 1, 0, 0, 0, "R7");
        step('h10, 0, 0, 1, 0, 0, 0, "R7");
        step('h08, 1, 0, 1, 0, 0, 0, "R7");
        step('h0C, 1, 'h01, 1, 0, 0, 0, "R7");
        step('h10, 1, 'hFF, 1, 0, 0, 0, "R7");
        step('h10, 0, 0, 1, 0, 0, 0, "R7");
        step('h08, 0, 0, 1, 0, 0, 0, "R7");
        step('h0C, 1, 0, 1, 0, 0, 0, "R7");

        // R8 interrupt tracks unmasked sources one cycle late
        step('h04, 0, 0, 1, 0, 0, 0, "R8");
        step('h04, 0, 0, 1, 2, 0, 0, "R8");
        step('h04, 0, 0, 1, 0, 0, 0, "R8");
        step('h04, 0, 0, 1, 0, 0, 0, "R8");
        step('h08, 1, 'h04, 0, 0, 0, 0, "R8");
        step('h04, 0, 0, 0, 0, 0, 0, "R8");
        step('h04, 0, 0, 3, 0, 0, 0, "R8");
        step('h04, 0, 0, 3, 0, 0, 0, "R8");

        // R9 full clear sequence
        step('h08, 1, -1, 63, 63, 1, 1, "R9");
        step('h04, 0, 0, 63, 63, 0, 0, "R9");
        step('h04, 1, -1, 63, 63, 0, 0, "R9");
        step('h0C, 1, -1, 63, 63, 0, 0, "R9");
        step('h10, 0, 0, 63, 63, 0, 0, "R9");
        step('h04, 0, 0, 63, 63, 0, 0, "R9");
        step('h04, 0, 0, 63, 63, 0, 0, "R9");

        // R10 threshold width and unmapped offsets
        step('h28, 1, 'hFFFF, 0, 0, 0, 0, "R10");
        step('h28, 0, 0, 0, 0, 0, 0, "R10");
        step('h2C, 1, 'h1_05, 0, 0, 0, 0, "R10");
        step('h2C, 0, 0, 0, 0, 0, 0, "R10");
        step('h00, 0, 0, 0, 0, 0, 0, "R10");
        step('h14, 1, -1, 0, 0, 0, 0, "R10");
        step('hA0, 0, 0, 0, 0, 0, 0, "R10");
        step('h04, 0, 0, 62, 5, 0, 0, "R10");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule